// File: doc/BRIEF.md
# Antenna Switch Control Register File

This block sits behind the serial-bus frame engine of an antenna switch slave. The frame engine presents each accepted register access as a one-cycle write or read request with a 5-bit register address. The block holds the slave's addressable registers and returns read data one cycle after a read request. It also keeps a status register. Error events reported by the frame engine, and accesses to addresses that hold no register, set flags in it.

The switch-state register feeds a throw decoder. The decoder drives a one-hot select vector with one bit for isolation and one bit for each of ten antenna throws. A group of trigger controls can be set so that switch-state writes wait in a shadow register. The decoder then sees them only when a trigger is fired, which lets several switches in a radio front end change state together.

Software can reset the block through the status register. The identity registers can be read back. The slave ID can be re-programmed behind an identity-match guard.

Top module: `swctl_regfile`

## Requirements
- R1: After reset, `path_sel` selects isolation (bit 0 only), `usid` is 4'b1010, `gsid` is 0, `pwr_mode` is 2'b10, the status register reads 0x00 and address 0x1C reads 0x80.
- R2: The low four bits of the switch state select the throw. Code 0010 selects RF1 (`path_sel` bit 1), 1010 RF2, 1110 RF3, 1011 RF4, 0001 RF5, 1001 RF6, 0110 RF7, 0100 RF8, 1100 RF9 and 1000 RF10 (bit 10). Every other code, including 0000, selects isolation (bit 0). Exactly one bit of `path_sel` is ever set.
- R3: With trigger mode off, a write to address 0x00 reaches `path_sel` at the clock edge that accepts the write. A read of 0x00 returns all 8 stored bits.
- R4: Address 0x1C bits 5:3 hold the trigger mask, and trigger mode is on while the mask is 111. In trigger mode a write to 0x00 goes only to a shadow. A write to 0x1C whose data has bits 5:3 = 111 and nonzero bits 2:0 copies the shadow to the active state. Bits 2:0 always read back as 0.
- R5: A write to 0x1C whose bits 2:0 are zero, or whose bits 5:3 are not 111, leaves the active switch state unchanged.
- R6: Address 0x1D reads 0x07 and 0x1E reads 0xB0. Address 0x1F reads {2'b00, 2'b01, usid}.
- R7: A write to 0x1F loads `usid` from data bits 3:0 only when data bits 5:4 equal 2'b01, the upper manufacturer ID bits. Otherwise `usid` is unchanged.
- R8: Address 0x1B stores data bits 3:0 as `gsid` and reads back {4'b0000, gsid}.
- R9: Each `evt_err` bit sets the status bit at the same position. Bit 6 is command parity, 5 command length, 4 address parity, 3 data parity and 0 broadcast/group read. A read of an unmapped address sets status bit 2 and returns 0x00. A write to an unmapped address sets status bit 1. Status bit 7 always reads 0.
- R10: A read of the status register (0x1A) returns its value and then clears all its bits.
- R11: A write to 0x1A with data bit 7 set clears the active switch state, the shadow and the status register. It leaves `usid`, `gsid` and register 0x1C unchanged.
- R12: `rd_valid` is high exactly in the cycle after a cycle with `rd_en`. `rd_data` is valid while `rd_valid` is high.
- R13: Writes to the read-only identity addresses 0x1D and 0x1E change nothing and raise no status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write request from the frame engine |
| rd_en | input | 1 | One-cycle read request from the frame engine |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| evt_err | input | 7 | Error event pulses, one per status flag 6:0 |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid |
| path_sel | output | 11 | One-hot throw select: bit 0 isolation, bit k throw RF k |
| usid | output | 4 | Current slave ID |
| gsid | output | 4 | Group slave ID |
| pwr_mode | output | 2 | Power mode: 00 active, 01 startup, 10 low power, 11 reserved |

## Verification
The bench builds the block with its default parameters. These are ten throws, 8-bit data, a 5-bit address and the trigger variant enabled (`TRIG_EN = 1`). With the shadow register present, the bench can drive the deferred-update path. That covers arming the mask, firing with and without valid trigger bits, and firing after a software reset has cleared the shadow. Because the default throw count is the full ten, the bench can sweep all sixteen switch codes against the complete decode table, including the undefined ones.

// File: rtl/swctl_pkg.sv
package swctl_pkg;

   localparam int unsigned MAX_THROWS = 10;

   localparam logic [4:0] A_SWITCH = 5'h00;
   localparam logic [4:0] A_STATUS = 5'h1A;
   localparam logic [4:0] A_GROUP  = 5'h1B;
   localparam logic [4:0] A_PMTRIG = 5'h1C;
   localparam logic [4:0] A_PROD   = 5'h1D;
   localparam logic [4:0] A_MFRLO  = 5'h1E;
   localparam logic [4:0] A_SLAVE  = 5'h1F;

   typedef enum logic [1:0] {
      PM_ACTIVE  = 2'b00,
      PM_STARTUP = 2'b01,
      PM_LOWPWR  = 2'b10,
      PM_RSVD    = 2'b11
   } pwr_mode_e;

   // Switch code that turns on throw number idx (1-based); 0 means no code.
   function automatic logic [3:0] throw_code(input int unsigned idx);
      case (idx)
         1:       throw_code = 4'b0010;
         2:       throw_code = 4'b1010;
         3:       throw_code = 4'b1110;
         4:       throw_code = 4'b1011;
         5:       throw_code = 4'b0001;
         6:       throw_code = 4'b1001;
         7:       throw_code = 4'b0110;
         8:       throw_code = 4'b0100;
         9:       throw_code = 4'b1100;
         10:      throw_code = 4'b1000;
         default: throw_code = 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/swctl_path_dec.sv
module swctl_path_dec #(
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned NUM_THROWS = 10
) (
   input  logic [CODE_W-1:0]   code,
   output logic [NUM_THROWS:0] sel
);
   import swctl_pkg::*;

   logic [NUM_THROWS:1] hit;

   generate
      for (genvar i = 1; i <= NUM_THROWS; i++) begin : g_throw
         assign hit[i] = (code == CODE_W'(throw_code(i)));
      end
   endgenerate

   // Isolation whenever no defined code matches.
   assign sel = {hit, ~(|hit)};

endmodule

// File: rtl/swctl_state.sv
module swctl_state #(
   parameter int unsigned DATA_W  = 8,
   parameter bit          TRIG_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              wr_state,
   input  logic              trig_mode,
   input  logic              fire,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] state_q
);

   generate
      if (TRIG_EN) begin : g_shadow
         logic [DATA_W-1:0] shadow_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow_q <= '0;
               state_q  <= '0;
            end else if (sw_rst) begin
               shadow_q <= '0;
               state_q  <= '0;
            end else begin
               if (wr_state) begin
                  shadow_q <= wdata;
               end
               if (wr_state && !trig_mode) begin
                  state_q <= wdata;
               end else if (fire) begin
                  state_q <= shadow_q;
               end
            end
         end
      end else begin : g_direct
         logic unused_trig;
         assign unused_trig = trig_mode ^ fire;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               state_q <= '0;
            end else if (sw_rst) begin
               state_q <= '0;
            end else if (wr_state) begin
               state_q <= wdata;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/swctl_status.sv
module swctl_status #(
   parameter int unsigned NFLAGS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              rd_clear,
   input  logic [NFLAGS-1:0] evt,
   output logic [NFLAGS-1:0] flags_q
);

   logic [NFLAGS-1:0] kept;

   // Events arriving in the same cycle as the clearing read survive it.
   assign kept = rd_clear ? '0 : flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (sw_rst) begin
         flags_q <= '0;
      end else begin
         flags_q <= kept | evt;
      end
   end

endmodule

// File: rtl/swctl_regfile.sv
module swctl_regfile #(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned NUM_THROWS = 10,
   parameter int unsigned ID_W       = 4,
   parameter int unsigned NFLAGS     = 7,
   parameter logic [7:0]  PROD_ID    = 8'h07,
   parameter logic [9:0]  MFR_ID     = 10'h1B0,
   parameter logic [3:0]  USID_RST   = 4'b1010,
   parameter logic [1:0]  PM_RST     = 2'b10,
   parameter bit          TRIG_EN    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [NFLAGS-1:0]     evt_err,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  rd_valid,
   output logic [NUM_THROWS:0]   path_sel,
   output logic [ID_W-1:0]       usid,
   output logic [ID_W-1:0]       gsid,
   output logic [1:0]            pwr_mode
);
   import swctl_pkg::*;

   localparam int unsigned MASK_LSB = 3;
   localparam int unsigned MASK_W   = 3;
   localparam int unsigned TRIG_W   = 3;
   localparam int unsigned PM_LSB   = MASK_LSB + MASK_W;
   localparam int unsigned SWR_BIT  = DATA_W - 1;
   localparam int unsigned UNRD_BIT = 2;
   localparam int unsigned UNWR_BIT = 1;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("swctl_regfile: DATA_W must be 8");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("swctl_regfile: ADDR_W must be at least 5");
      end
      if (NUM_THROWS < 1 || NUM_THROWS > MAX_THROWS) begin : g_bad_throws
         $error("swctl_regfile: NUM_THROWS out of range");
      end
      if (CODE_W != 4 || ID_W != 4 || NFLAGS != 7) begin : g_bad_fields
         $error("swctl_regfile: field widths are fixed by the register map");
      end
   endgenerate

   // ---------------- address decode ----------------
   logic hit_sw, hit_st, hit_grp, hit_pm, hit_prod, hit_mfr, hit_sid, hit_any;

   assign hit_sw   = (addr == ADDR_W'(A_SWITCH));
   assign hit_st   = (addr == ADDR_W'(A_STATUS));
   assign hit_grp  = (addr == ADDR_W'(A_GROUP));
   assign hit_pm   = (addr == ADDR_W'(A_PMTRIG));
   assign hit_prod = (addr == ADDR_W'(A_PROD));
   assign hit_mfr  = (addr == ADDR_W'(A_MFRLO));
   assign hit_sid  = (addr == ADDR_W'(A_SLAVE));
   assign hit_any  = hit_sw | hit_st | hit_grp | hit_pm | hit_prod | hit_mfr | hit_sid;

   logic sw_rst, st_clear, unused_wr, unused_rd;

   assign sw_rst    = wr_en && hit_st && wdata[SWR_BIT];
   assign st_clear  = rd_en && hit_st;
   assign unused_wr = wr_en && !hit_any;
   assign unused_rd = rd_en && !hit_any;

   // ---------------- power mode / trigger register ----------------
   logic [1:0]        pm_q;
   logic [MASK_W-1:0] mask_q;
   logic              trig_mode, fire;
   logic [MASK_W-1:0] wr_mask;
   logic [TRIG_W-1:0] wr_trig;

   assign wr_mask   = wdata[MASK_LSB +: MASK_W];
   assign wr_trig   = wdata[TRIG_W-1:0];
   assign trig_mode = &mask_q;
   assign fire      = TRIG_EN && wr_en && hit_pm && (&wr_mask) && (|wr_trig);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pm_q   <= PM_RST;
         mask_q <= '0;
      end else if (wr_en && hit_pm) begin
         pm_q   <= wdata[PM_LSB +: 2];
         mask_q <= wr_mask;
      end
   end

   // ---------------- group and slave IDs ----------------
   logic [ID_W-1:0] gsid_q, usid_q;
   logic            sid_match;

   assign sid_match = (wdata[ID_W +: 2] == MFR_ID[9:8]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gsid_q <= '0;
         usid_q <= USID_RST;
      end else begin
         if (wr_en && hit_grp) begin
            gsid_q <= wdata[ID_W-1:0];
         end
         if (wr_en && hit_sid && sid_match) begin
            usid_q <= wdata[ID_W-1:0];
         end
      end
   end

   // ---------------- switch state and status ----------------
   logic [DATA_W-1:0] state_q;
   logic [NFLAGS-1:0] flags_q;
   logic [NFLAGS-1:0] evt_all;

   always_comb begin
      evt_all           = evt_err;
      evt_all[UNRD_BIT] = evt_err[UNRD_BIT] | unused_rd;
      evt_all[UNWR_BIT] = evt_err[UNWR_BIT] | unused_wr;
   end

   swctl_state #(
      .DATA_W  (DATA_W),
      .TRIG_EN (TRIG_EN)
   ) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_rst    (sw_rst),
      .wr_state  (wr_en && hit_sw),
      .trig_mode (trig_mode),
      .fire      (fire),
      .wdata     (wdata),
      .state_q   (state_q)
   );

   swctl_status #(
      .NFLAGS (NFLAGS)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_rst   (sw_rst),
      .rd_clear (st_clear),
      .evt      (evt_all),
      .flags_q  (flags_q)
   );

   swctl_path_dec #(
      .CODE_W     (CODE_W),
      .NUM_THROWS (NUM_THROWS)
   ) u_dec (
      .code (state_q[CODE_W-1:0]),
      .sel  (path_sel)
   );

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (hit_sw)   rd_mux = state_q;
      if (hit_st)   rd_mux = {1'b0, flags_q};
      if (hit_grp)  rd_mux = {{(DATA_W-ID_W){1'b0}}, gsid_q};
      if (hit_pm)   rd_mux = {pm_q, mask_q, {TRIG_W{1'b0}}};
      if (hit_prod) rd_mux = PROD_ID;
      if (hit_mfr)  rd_mux = MFR_ID[7:0];
      if (hit_sid)  rd_mux = {2'b00, MFR_ID[9:8], usid_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_data <= rd_mux;
         end
      end
   end

   assign usid     = usid_q;
   assign gsid     = gsid_q;
   assign pwr_mode = pm_q;

endmodule

// File: rtl/swctl_regfile_chk.sv
module swctl_regfile_chk #(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_THROWS = 10,
   parameter int unsigned ID_W       = 4,
   parameter logic [7:0]  PROD_ID    = 8'h07,
   parameter logic [9:0]  MFR_ID     = 10'h1B0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic                rd_en,
   input logic [ADDR_W-1:0]   addr,
   input logic [DATA_W-1:0]   wdata,
   input logic [DATA_W-1:0]   rd_data,
   input logic                rd_valid,
   input logic [NUM_THROWS:0] path_sel,
   input logic [ID_W-1:0]     usid,
   input logic [ID_W-1:0]     gsid,
   input logic [1:0]          pwr_mode
);

   // R2: exactly one throw or isolation is on.
   a_r2_one_throw: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(path_sel) == 1);

   // R12: read data follows a request by one cycle.
   a_r12_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   // R12: no valid without a request.
   a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   // R6: product ID readback.
   a_r6_prod_id: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(5'h1D)) |=> (rd_data == PROD_ID));

   // R7: slave ID holds unless a matching write arrives.
   a_r7_usid_guard: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(5'h1F) && wdata[ID_W +: 2] == MFR_ID[9:8])
      |=> $stable(usid));

   // R11: software reset forces isolation.
   a_r11_swrst_iso: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(5'h1A) && wdata[DATA_W-1])
      |=> (path_sel == (NUM_THROWS+1)'(1)));

   // R11: software reset spares the IDs and the power-mode register.
   a_r11_swrst_spares: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(5'h1A) && wdata[DATA_W-1])
      |=> ($stable(usid) && $stable(gsid) && $stable(pwr_mode)));

endmodule

bind swctl_regfile swctl_regfile_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .NUM_THROWS (NUM_THROWS),
   .ID_W       (ID_W),
   .PROD_ID    (PROD_ID),
   .MFR_ID     (MFR_ID)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wdata    (wdata),
   .rd_data  (rd_data),
   .rd_valid (rd_valid),
   .path_sel (path_sel),
   .usid     (usid),
   .gsid     (gsid),
   .pwr_mode (pwr_mode)
);

// File: tb/swctl_regfile_bench.sv
module swctl_regfile_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [6:0]  evt_err = '0;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic [10:0] path_sel;
   logic [3:0]  usid;
   logic [3:0]  gsid;
   logic [1:0]  pwr_mode;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   swctl_regfile u_swctl_regfile (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .evt_err  (evt_err),
      .rd_data  (rd_data),
      .rd_valid (rd_valid),
      .path_sel (path_sel),
      .usid     (usid),
      .gsid     (gsid),
      .pwr_mode (pwr_mode)
   );

   // Expected one-hot select from the decode table of R2.
   function automatic logic [10:0] exp_path(input logic [3:0] c);
      case (c)
         4'b0010: exp_path = 11'd1 << 1;
         4'b1010: exp_path = 11'd1 << 2;
         4'b1110: exp_path = 11'd1 << 3;
         4'b1011: exp_path = 11'd1 << 4;
         4'b0001: exp_path = 11'd1 << 5;
         4'b1001: exp_path = 11'd1 << 6;
         4'b0110: exp_path = 11'd1 << 7;
         4'b0100: exp_path = 11'd1 << 8;
         4'b1100: exp_path = 11'd1 << 9;
         4'b1000: exp_path = 11'd1 << 10;
         default: exp_path = 11'd1;
      endcase
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Driver: pushes the expected read value, then issues the request.
   task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // Monitor: pops and compares each returned read.
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            check("R12 unexpected rd_valid", 16'(rd_valid), 16'd0);
         end else begin
            check(tag_q.pop_front(), 16'(rd_data), 16'(exp_q.pop_front()));
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 path isolation", 16'(path_sel), 16'd1);
      check("R1 usid", 16'(usid), 16'hA);
      check("R1 gsid", 16'(gsid), 16'h0);
      check("R1 pwr_mode", 16'(pwr_mode), 16'h2);
      check("R12 idle rd_valid", 16'(rd_valid), 16'd0);
      rd(5'h1A, 8'h00, "R1 status reset");
      rd(5'h1C, 8'h80, "R1 pm/trigger reset");

      // R6 identity
      rd(5'h1D, 8'h07, "R6 product id");
      rd(5'h1E, 8'hB0, "R6 mfr id low");
      rd(5'h1F, 8'h1A, "R6 mfr high and usid");

      // R2 / R3 full code sweep in direct mode
      for (int c = 0; c < 16; c++) begin
         wr(5'h00, 8'(c));
         check($sformatf("R2 R3 decode code %0d", c), 16'(path_sel), 16'(exp_path(4'(c))));
      end
      wr(5'h00, 8'h3F);
      check("R2 undefined code isolation", 16'(path_sel), 16'd1);
      rd(5'h00, 8'h3F, "R3 switch readback");

      // R13 read-only identity writes
      wr(5'h1D, 8'hFF);
      wr(5'h1E, 8'h00);
      rd(5'h1D, 8'h07, "R13 product id unchanged");
      rd(5'h1E, 8'hB0, "R13 mfr id unchanged");
      rd(5'h1A, 8'h00, "R13 no status flag");

      // R9 / R10 status flags
      @(negedge clk);
      evt_err = 7'h55;
      @(negedge clk);
      evt_err = '0;
      rd(5'h1A, 8'h55, "R9 event flags");
      rd(5'h1A, 8'h00, "R10 cleared on read");
      wr(5'h05, 8'hAA);
      rd(5'h1A, 8'h02, "R9 unused write flag");
      rd(5'h07, 8'h00, "R9 unused read data");
      rd(5'h1A, 8'h04, "R9 unused read flag");

      // R8 group ID
      wr(5'h1B, 8'hF5);
      check("R8 gsid", 16'(gsid), 16'h5);
      rd(5'h1B, 8'h05, "R8 group readback");

      // R7 slave ID guard
      wr(5'h1F, 8'h23);
      check("R7 mismatched usid write ignored", 16'(usid), 16'hA);
      wr(5'h1F, 8'h13);
      check("R7 matched usid write", 16'(usid), 16'h3);
      rd(5'h1F, 8'h13, "R7 usid readback");

      // R4 triggered update
      wr(5'h00, 8'h02);
      check("R3 direct RF1", 16'(path_sel), 16'(exp_path(4'b0010)));
      wr(5'h1C, 8'h38);
      check("R5 mask only, no fire", 16'(path_sel), 16'(exp_path(4'b0010)));
      check("R4 pwr_mode written", 16'(pwr_mode), 16'h0);
      wr(5'h00, 8'h0E);
      check("R4 shadowed write held", 16'(path_sel), 16'(exp_path(4'b0010)));
      rd(5'h00, 8'h02, "R4 active state readback");
      wr(5'h1C, 8'h39);
      check("R4 trigger fires RF3", 16'(path_sel), 16'(exp_path(4'b1110)));
      rd(5'h1C, 8'h38, "R4 trigger bits self-clear");

      // R5 non-firing writes
      wr(5'h00, 8'h08);
      wr(5'h1C, 8'h38);
      check("R5 zero trigger no fire", 16'(path_sel), 16'(exp_path(4'b1110)));
      wr(5'h1C, 8'h19);
      check("R5 mask not 111 no fire", 16'(path_sel), 16'(exp_path(4'b1110)));
      wr(5'h1C, 8'h3C);
      check("R4 fire copies shadow RF10", 16'(path_sel), 16'(exp_path(4'b1000)));

      // R11 software reset
      @(negedge clk);
      evt_err = 7'h08;
      @(negedge clk);
      evt_err = '0;
      wr(5'h1A, 8'h80);
      check("R11 isolation after reset", 16'(path_sel), 16'd1);
      check("R11 usid kept", 16'(usid), 16'h3);
      check("R11 gsid kept", 16'(gsid), 16'h5);
      rd(5'h00, 8'h00, "R11 switch state cleared");
      rd(5'h1A, 8'h00, "R11 status cleared");
      rd(5'h1C, 8'h38, "R11 pm/trigger kept");
      rd(5'h1F, 8'h13, "R11 usid readback kept");
      wr(5'h1C, 8'h39);
      check("R11 shadow cleared", 16'(path_sel), 16'd1);

      repeat (3) @(negedge clk);
      check("R12 all reads returned", 16'(exp_q.size()), 16'd0);
      finish_run();
   end

endmodule